// File: doc/BRIEF.md
# Thermal Input Fan Boost Override

This block sits between the fan duty-cycle generator and the PWM output stage. It passes the normal fan duty through to the PWM stage. The normal duty is the programmed manual value in manual mode and the computed value in automatic mode. When an active-low thermal-event pin is held low, the block can instead force the duty to full scale. Typical sources for that pin are a processor hot signal or a trip-point sensor.

The override is conditional. Both the pin function and the boost function must be enabled, and the fan must already be spinning. In manual mode, spinning means the manual duty is nonzero. In automatic mode, it means the measured temperature is strictly above the minimum threshold. A stopped fan is therefore never kicked to full speed.

The pin is asynchronous. It passes through a synchronizer and then a run-length qualifier, so that short low glitches are ignored. The duty output is registered, and every select input is re-evaluated on every clock.

Top module: `fan_boost_ovr`

## Requirements
- R1: While `rst_n` is low, `duty_out` is 0.
- R2: With no qualified thermal event, `duty_out` equals `man_duty` when `mode_sel`=1 (manual) and `auto_duty` when `mode_sel`=0 (automatic), one clock after the inputs are applied.
- R3: With `pin_en`=1, `boost_en`=1 and the fan running, a low `therm_n` gives `duty_out` = all ones. This happens on the (SYNC_STAGES+CONFIRM_LEN)-th rising edge after the low level is set up, and the value holds for as long as the pin stays low.
- R4: With `boost_en`=0, the level of `therm_n` never changes `duty_out`.
- R5: With `pin_en`=0, the level of `therm_n` never changes `duty_out`.
- R6: In manual mode with `man_duty`=0, `duty_out` stays 0 while `therm_n` is low.
- R7: In automatic mode with `temp` at or below `temp_min` (unsigned compare), `duty_out` follows `auto_duty` while `therm_n` is low.
- R8: A low pulse on `therm_n` that lasts fewer than CONFIRM_LEN clock cycles never changes `duty_out`.
- R9: After `therm_n` returns high, `duty_out` goes back to the normal duty on the (SYNC_STAGES+1)-th rising edge, with no extra hold-off.
- R10: A change of `mode_sel` during a boost takes effect on `duty_out` at the next rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| therm_n | input | 1 | Asynchronous active-low thermal-event pin |
| pin_en | input | 1 | Pin function enable |
| boost_en | input | 1 | Full-speed override enable |
| mode_sel | input | 1 | 1 = manual duty, 0 = automatic duty |
| man_duty | input | DUTY_W | Programmed manual duty |
| auto_duty | input | DUTY_W | Automatically computed duty |
| temp | input | TEMP_W | Current temperature, unsigned |
| temp_min | input | TEMP_W | Minimum-temperature threshold, unsigned |
| duty_out | output | DUTY_W | Registered duty sent to the PWM stage |

## Verification
The bench builds the block with its default parameters: 8-bit duty and temperature, two synchronizer stages and a two-sample qualifier. With these values the assertion and release latencies are four and three edges. The bench derives those latencies from the parameters, so the cycle exactly before each switch and the cycle exactly on it can both be checked. The short qualifier also lets a one-cycle glitch probe the rejection boundary directly. Separately, a mode flip in the middle of a boost exercises the per-cycle re-evaluation.

// File: rtl/fboost_pkg.sv
package fboost_pkg;

  typedef enum logic {
    FB_MODE_AUTO   = 1'b0,
    FB_MODE_MANUAL = 1'b1
  } fb_mode_e;

endpackage

// File: rtl/fboost_sync.sv
// Brings the asynchronous active-low pin into the clock domain and
// flags an event only after CONFIRM_LEN consecutive synchronized lows.
module fboost_sync #(
  parameter int SYNC_STAGES = 2,
  parameter int CONFIRM_LEN = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_n,
  output logic active
);

  localparam int HIST_W = (CONFIRM_LEN > 1) ? CONFIRM_LEN - 1 : 1;

  logic [SYNC_STAGES-1:0] sync_q, sync_d;
  logic                   pin_s;

  // Synchronizer chain: next-state logic
  always_comb begin
    sync_d[0] = pin_n;
    for (int i = 1; i < SYNC_STAGES; i++) begin
      sync_d[i] = sync_q[i-1];
    end
  end

  // Synchronizer chain: registers, idle level is high
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '1;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign pin_s = sync_q[SYNC_STAGES-1];

  generate
    if (CONFIRM_LEN > 1) begin : g_qual
      logic [HIST_W-1:0] hist_q, hist_d;

      always_comb begin
        hist_d[0] = pin_s;
        for (int j = 1; j < HIST_W; j++) begin
          hist_d[j] = hist_q[j-1];
        end
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          hist_q <= '1;
        end else begin
          hist_q <= hist_d;
        end
      end

      assign active = ~(|{hist_q, pin_s});
    end else begin : g_noqual
      assign active = ~pin_s;
    end
  endgenerate

endmodule

// File: rtl/fboost_sel.sv
// Decides whether the fan is running and whether the override applies,
// then picks the next duty value.
module fboost_sel
  import fboost_pkg::*;
#(
  parameter int DUTY_W = 8,
  parameter int TEMP_W = 8
) (
  input  logic              ev_active,
  input  logic              pin_en,
  input  logic              boost_en,
  input  fb_mode_e          mode,
  input  logic [DUTY_W-1:0] man_duty,
  input  logic [DUTY_W-1:0] auto_duty,
  input  logic [TEMP_W-1:0] temp,
  input  logic [TEMP_W-1:0] temp_min,
  output logic              boost,
  output logic [DUTY_W-1:0] duty_nxt
);

  localparam logic [DUTY_W-1:0] FULL_SCALE = '1;

  logic              fan_running;
  logic [DUTY_W-1:0] base_duty;

  always_comb begin
    if (mode == FB_MODE_MANUAL) begin
      base_duty   = man_duty;
      fan_running = (man_duty != '0);
    end else begin
      base_duty   = auto_duty;
      fan_running = (temp > temp_min);
    end
    boost    = pin_en & boost_en & ev_active & fan_running;
    duty_nxt = boost ? FULL_SCALE : base_duty;
  end

endmodule

// File: rtl/fan_boost_ovr.sv
module fan_boost_ovr
  import fboost_pkg::*;
#(
  parameter int DUTY_W      = 8,
  parameter int TEMP_W      = 8,
  parameter int SYNC_STAGES = 2,
  parameter int CONFIRM_LEN = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              therm_n,
  input  logic              pin_en,
  input  logic              boost_en,
  input  logic              mode_sel,
  input  logic [DUTY_W-1:0] man_duty,
  input  logic [DUTY_W-1:0] auto_duty,
  input  logic [TEMP_W-1:0] temp,
  input  logic [TEMP_W-1:0] temp_min,
  output logic [DUTY_W-1:0] duty_out
);

  logic              therm_act;
  logic              boost_now;
  logic [DUTY_W-1:0] duty_d, duty_q;
  fb_mode_e          mode;

  assign mode = fb_mode_e'(mode_sel);

  fboost_sync #(
    .SYNC_STAGES(SYNC_STAGES),
    .CONFIRM_LEN(CONFIRM_LEN)
  ) sync_i (
    .clk   (clk),
    .rst_n (rst_n),
    .pin_n (therm_n),
    .active(therm_act)
  );

  fboost_sel #(
    .DUTY_W(DUTY_W),
    .TEMP_W(TEMP_W)
  ) sel_i (
    .ev_active(therm_act),
    .pin_en   (pin_en),
    .boost_en (boost_en),
    .mode     (mode),
    .man_duty (man_duty),
    .auto_duty(auto_duty),
    .temp     (temp),
    .temp_min (temp_min),
    .boost    (boost_now),
    .duty_nxt (duty_d)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      duty_q <= '0;
    end else begin
      duty_q <= duty_d;
    end
  end

  assign duty_out = duty_q;

endmodule

// File: rtl/fboost_chk.sv
module fboost_chk #(
  parameter int DUTY_W = 8,
  parameter int TEMP_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              pin_en,
  input logic              boost_en,
  input logic              mode_sel,
  input logic [DUTY_W-1:0] man_duty,
  input logic [DUTY_W-1:0] auto_duty,
  input logic [TEMP_W-1:0] temp,
  input logic [TEMP_W-1:0] temp_min,
  input logic              act,
  input logic [DUTY_W-1:0] duty_out
);

  p_reset_zero_r1: assert property (@(posedge clk)
    !rst_n |-> (duty_out == '0));

  p_full_scale_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_en && boost_en && act &&
     (mode_sel ? (man_duty != '0) : (temp > temp_min)))
    |=> (duty_out == {DUTY_W{1'b1}}));

  p_boost_off_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !boost_en |=>
    (duty_out == ($past(mode_sel) ? $past(man_duty) : $past(auto_duty))));

  p_pin_off_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !pin_en |=>
    (duty_out == ($past(mode_sel) ? $past(man_duty) : $past(auto_duty))));

  p_manual_stopped_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_sel && (man_duty == '0)) |=> (duty_out == '0));

  p_auto_cold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_sel && (temp <= temp_min)) |=> (duty_out == $past(auto_duty)));

endmodule

bind fan_boost_ovr fboost_chk #(
  .DUTY_W(DUTY_W),
  .TEMP_W(TEMP_W)
) chk_i (
  .clk      (clk),
  .rst_n    (rst_n),
  .pin_en   (pin_en),
  .boost_en (boost_en),
  .mode_sel (mode_sel),
  .man_duty (man_duty),
  .auto_duty(auto_duty),
  .temp     (temp),
  .temp_min (temp_min),
  .act      (therm_act),
  .duty_out (duty_out)
);

// File: tb/fan_boost_ovr_tb_top.sv
`timescale 1ns/1ps
module fan_boost_ovr_tb_top;

  localparam int DUTY_W  = 8;
  localparam int TEMP_W  = 8;
  localparam int SYNC    = 2;
  localparam int CONFIRM = 2;
  localparam int LAT_ON  = SYNC + CONFIRM;
  localparam int LAT_OFF = SYNC + 1;
  localparam logic [DUTY_W-1:0] FULL = '1;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              therm_n = 1'b1;
  logic              pin_en = 1'b1;
  logic              boost_en = 1'b1;
  logic              mode_sel = 1'b1;
  logic [DUTY_W-1:0] man_duty = 8'h40;
  logic [DUTY_W-1:0] auto_duty = 8'h30;
  logic [TEMP_W-1:0] temp = 8'd60;
  logic [TEMP_W-1:0] temp_min = 8'd50;
  logic [DUTY_W-1:0] duty_out;

  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;

  fan_boost_ovr #(
    .DUTY_W(DUTY_W), .TEMP_W(TEMP_W),
    .SYNC_STAGES(SYNC), .CONFIRM_LEN(CONFIRM)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .therm_n(therm_n), .pin_en(pin_en),
    .boost_en(boost_en), .mode_sel(mode_sel), .man_duty(man_duty),
    .auto_duty(auto_duty), .temp(temp), .temp_min(temp_min),
    .duty_out(duty_out)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [DUTY_W-1:0] exp);
    checks++;
    if (duty_out !== exp) begin
      fails++;
      $display("FAIL %s: duty_out=%h expected=%h at %0t", tag, duty_out, exp, $time);
    end
  endtask

  task automatic settle();
    therm_n = 1'b1;
    pin_en = 1'b1; boost_en = 1'b1; mode_sel = 1'b1;
    man_duty = 8'h40; auto_duty = 8'h30; temp = 8'd60; temp_min = 8'd50;
    tick(LAT_OFF + 2);
  endtask

  task automatic t_reset();
    tick(2);
    chk("R1 reset holds zero", 8'h00);
    rst_n = 1'b1;
    tick(1);
    chk("R2 manual after reset", 8'h40);
  endtask

  task automatic t_normal();
    mode_sel = 1'b0; auto_duty = 8'h90;
    tick(1);
    chk("R2 auto passthrough", 8'h90);
    mode_sel = 1'b1; man_duty = 8'h21;
    tick(1);
    chk("R2 manual passthrough", 8'h21);
  endtask

  task automatic t_boost_manual();
    settle();
    therm_n = 1'b0;
    tick(LAT_ON - 1);
    chk("R3 not yet boosted", 8'h40);
    tick(1);
    chk("R3 boost manual", FULL);
    tick(10);
    chk("R3 boost held", FULL);
    therm_n = 1'b1;
    tick(LAT_OFF - 1);
    chk("R9 still boosted before release edge", FULL);
    tick(1);
    chk("R9 release to manual", 8'h40);
  endtask

  task automatic t_boost_auto();
    settle();
    mode_sel = 1'b0; temp = 8'd51;
    therm_n = 1'b0;
    tick(LAT_ON);
    chk("R3 boost auto just above min", FULL);
    therm_n = 1'b1;
    tick(LAT_OFF);
    chk("R9 release to auto", 8'h30);
  endtask

  task automatic t_boost_off();
    settle();
    boost_en = 1'b0;
    therm_n = 1'b0;
    tick(LAT_ON + 3);
    chk("R4 boost disabled", 8'h40);
  endtask

  task automatic t_pin_off();
    settle();
    pin_en = 1'b0;
    therm_n = 1'b0;
    tick(LAT_ON + 3);
    chk("R5 pin disabled", 8'h40);
  endtask

  task automatic t_man_zero();
    settle();
    man_duty = 8'h00;
    therm_n = 1'b0;
    tick(LAT_ON + 3);
    chk("R6 manual zero stays off", 8'h00);
  endtask

  task automatic t_auto_cold();
    settle();
    mode_sel = 1'b0; temp = 8'd50; auto_duty = 8'h00;
    therm_n = 1'b0;
    tick(LAT_ON + 3);
    chk("R7 temp equal to min", 8'h00);
    temp = 8'd20; auto_duty = 8'h05;
    tick(1);
    chk("R7 temp below min follows auto", 8'h05);
  endtask

  task automatic t_glitch();
    settle();
    therm_n = 1'b0;
    tick(CONFIRM - 1);
    therm_n = 1'b1;
    for (int k = 0; k < LAT_ON + 3; k++) begin
      tick(1);
      chk("R8 short pulse ignored", 8'h40);
    end
  endtask

  task automatic t_mode_switch();
    settle();
    auto_duty = 8'h10; temp = 8'd10;
    therm_n = 1'b0;
    tick(LAT_ON);
    chk("R10 boosted before switch", FULL);
    mode_sel = 1'b0;
    tick(1);
    chk("R10 switch to cold auto", 8'h10);
    mode_sel = 1'b1;
    tick(1);
    chk("R10 switch back to manual", FULL);
    therm_n = 1'b1;
    tick(LAT_OFF);
  endtask

  initial begin
    t_reset();
    t_normal();
    t_boost_manual();
    t_boost_auto();
    t_boost_off();
    t_pin_off();
    t_man_zero();
    t_auto_cold();
    t_glitch();
    t_mode_switch();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule